// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen interrupt request lines into a single request to the processor. The lines are one non-maskable input, one debug-port input, six external lines, four DMA channel-end lines and four serial-port lines. Software gives each external line, the DMA group and the serial group a 4-bit level. The non-maskable and debug inputs have fixed levels 16 and 15. The controller picks the requesting source with the highest level. When several sources share that level, a fixed order decides between them. The winner is raised to the processor only when its level is above the processor's current 4-bit mask.

When the processor accepts the request, the controller loads two event-code registers. The source code gives every source its own 12-bit value. The level code gives a value that depends on the winner's level. A single shared service routine can use either code as a branch offset to find the source.

Three 16-bit level registers are reached through a small register port. Writes take effect at the clock edge. Read data is registered.

Top module: `vic_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `int_req` is 0, both event codes are 0x000, and every level register reads back 0.
- R2: Writes to the level registers take effect at the clock edge where `reg_wr` is high. `reg_rdata` shows, one cycle later, the register selected by `reg_addr` before that edge. The registers are: address 0, the external line levels (line k at bits [4k+3:4k], k=0..3); address 1, line 4 at [3:0] and line 5 at [7:4]; address 2, the serial group at [7:4] and the DMA group at [15:12]. All other bits, and address 3, read 0.
- R3: A source whose programmed level is 0 never raises `int_req` and is never captured.
- R4: A maskable source is eligible only when its level is strictly greater than `cpu_mask`. The debug source therefore loses to a mask of 15. The non-maskable source is always eligible.
- R5: `int_req` is registered. In each cycle it shows whether any source was eligible at the previous clock edge.
- R6: Among eligible sources, the one with the highest level wins.
- R7: Ties are broken in this order: non-maskable, debug, external 0..5, DMA 0..3, then serial error, receive, break, transmit.
- R8: The source code is 0x1C0 for non-maskable and 0x5E0 for debug. External line k gives 0x600+0x20·k, DMA channel k gives 0x800+0x20·k, and serial source k (in the R7 order) gives 0x900+0x20·k.
- R9: The level code is 0x1C0 for non-maskable and 0x5E0 for debug. For every other source it is 0x200+(15−level)·0x20.
- R10: Both codes load at the clock edge where `int_ack` is high and a source is eligible, using that edge's winner. They hold their value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request |
| dbg_in | input | 1 | Debug-port request |
| ext_in | input | 6 | External request lines 0..5 |
| dma_in | input | 4 | DMA channel-end requests 0..3 |
| ser_in | input | 4 | Serial requests: error, receive, break, transmit |
| cpu_mask | input | 4 | Processor interrupt mask level |
| int_ack | input | 1 | Processor accepts the current request |
| int_req | output | 1 | Interrupt request to the processor |
| evt_code_lvl | output | 12 | Level-dependent event code |
| evt_code_src | output | 12 | Per-source event code |
| reg_addr | input | 2 | Level register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
Single requests are driven first, one source at a time. These show that each source's level field and its two codes are wired correctly. Then two or more sources request together, at different levels and at equal levels. These patterns separate level-based selection from the fixed tie order, inside the DMA and serial groups and across them. Mask sweeps around a source's level show the strict greater-than rule, including the fixed debug level against mask 15. Holding requests while `int_ack` toggles shows that capture happens only on acceptance. A long random run, with register writes mixed in, is compared cycle by cycle against a behavioural model.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int CODE_W = 12;
  localparam logic [CODE_W-1:0] CODE_NMI  = 12'h1C0;
  localparam logic [CODE_W-1:0] CODE_DBG  = 12'h5E0;
  localparam logic [CODE_W-1:0] BASE_LVL  = 12'h200;
  localparam logic [CODE_W-1:0] BASE_EXT  = 12'h600;
  localparam logic [CODE_W-1:0] BASE_DMA  = 12'h800;
  localparam logic [CODE_W-1:0] BASE_SER  = 12'h900;
  localparam logic [CODE_W-1:0] CODE_STEP = 12'h020;
endpackage

// File: rtl/vic_prio_regs.sv
module vic_prio_regs #(
  parameter int NUM_EXT = 6,
  parameter int NUM_DMA = 4,
  parameter int NUM_SER = 4,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 16,
  localparam int NSRC   = 2 + NUM_EXT + NUM_DMA + NUM_SER
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    reg_addr,
  input  logic                          reg_wr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic [NSRC-1:0][LVL_W:0]      src_lvl
);
  localparam int FPR = DATA_W / LVL_W;
  localparam int HI_FIELDS = NUM_EXT - FPR;
  localparam logic [DATA_W-1:0] HI_MASK  = DATA_W'((1 << (HI_FIELDS * LVL_W)) - 1);
  localparam logic [DATA_W-1:0] FLD_ONES = DATA_W'((1 << LVL_W) - 1);
  localparam logic [DATA_W-1:0] GRP_MASK = (FLD_ONES << (3 * LVL_W)) | (FLD_ONES << LVL_W);
  localparam logic [LVL_W:0] NMI_LVL = (LVL_W+1)'(1 << LVL_W);
  localparam logic [LVL_W:0] DBG_LVL = NMI_LVL - 1'b1;

  logic [DATA_W-1:0] lo_q, hi_q, grp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      hi_q      <= '0;
      grp_q     <= '0;
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        2'd0:    reg_rdata <= lo_q;
        2'd1:    reg_rdata <= hi_q;
        2'd2:    reg_rdata <= grp_q;
        default: reg_rdata <= '0;
      endcase
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    lo_q  <= reg_wdata;
          2'd1:    hi_q  <= reg_wdata & HI_MASK;
          2'd2:    grp_q <= reg_wdata & GRP_MASK;
          default: ;
        endcase
      end
    end
  end

  assign src_lvl[0] = NMI_LVL;
  assign src_lvl[1] = DBG_LVL;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    if (i < FPR) begin : g_lo
      assign src_lvl[2+i] = {1'b0, lo_q[i*LVL_W +: LVL_W]};
    end else begin : g_hi
      assign src_lvl[2+i] = {1'b0, hi_q[(i-FPR)*LVL_W +: LVL_W]};
    end
  end
  for (genvar i = 0; i < NUM_DMA; i++) begin : g_dma
    assign src_lvl[2+NUM_EXT+i] = {1'b0, grp_q[3*LVL_W +: LVL_W]};
  end
  for (genvar i = 0; i < NUM_SER; i++) begin : g_ser
    assign src_lvl[2+NUM_EXT+NUM_DMA+i] = {1'b0, grp_q[LVL_W +: LVL_W]};
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NSRC  = 16,
  parameter int LVL_W = 4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             req,
  input  logic [NSRC-1:0][LVL_W:0]    lvl,
  input  logic [LVL_W-1:0]            mask,
  output logic                        win_valid,
  output logic [IDX_W-1:0]            win_idx,
  output logic [LVL_W:0]              win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && (lvl[i] > {1'b0, mask}) && (lvl[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/vic_code_gen.sv
module vic_code_gen
  import vic_pkg::*;
#(
  parameter int NUM_EXT = 6,
  parameter int NUM_DMA = 4,
  parameter int LVL_W   = 4,
  parameter int IDX_W   = 4
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [LVL_W:0]     lvl,
  output logic [CODE_W-1:0]  code_lvl,
  output logic [CODE_W-1:0]  code_src
);
  localparam int DMA_FIRST = 2 + NUM_EXT;
  localparam int SER_FIRST = DMA_FIRST + NUM_DMA;
  localparam int MAX_LVL   = (1 << LVL_W) - 1;

  always_comb begin
    if (idx == IDX_W'(0)) begin
      code_lvl = CODE_NMI;
      code_src = CODE_NMI;
    end else if (idx == IDX_W'(1)) begin
      code_lvl = CODE_DBG;
      code_src = CODE_DBG;
    end else begin
      code_lvl = BASE_LVL + CODE_W'(MAX_LVL - int'(lvl)) * CODE_STEP;
      if (int'(idx) < DMA_FIRST)
        code_src = BASE_EXT + CODE_W'(int'(idx) - 2) * CODE_STEP;
      else if (int'(idx) < SER_FIRST)
        code_src = BASE_DMA + CODE_W'(int'(idx) - DMA_FIRST) * CODE_STEP;
      else
        code_src = BASE_SER + CODE_W'(int'(idx) - SER_FIRST) * CODE_STEP;
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_EXT = 6,
  parameter int NUM_DMA = 4,
  parameter int NUM_SER = 4,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 nmi_in,
  input  logic                 dbg_in,
  input  logic [NUM_EXT-1:0]   ext_in,
  input  logic [NUM_DMA-1:0]   dma_in,
  input  logic [NUM_SER-1:0]   ser_in,
  input  logic [LVL_W-1:0]     cpu_mask,
  input  logic                 int_ack,
  output logic                 int_req,
  output logic [CODE_W-1:0]    evt_code_lvl,
  output logic [CODE_W-1:0]    evt_code_src,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata
);
  localparam int NSRC  = 2 + NUM_EXT + NUM_DMA + NUM_SER;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0][LVL_W:0] src_lvl;
  logic [NSRC-1:0]          src_req;
  logic                     cand_valid;
  logic [IDX_W-1:0]         win_idx;
  logic [LVL_W:0]           win_lvl;
  logic [CODE_W-1:0]        nxt_lvl_code, nxt_src_code;
  logic                     accept;

  assign src_req = {ser_in, dma_in, ext_in, dbg_in, nmi_in};
  assign accept  = int_ack && cand_valid;

  vic_prio_regs #(.NUM_EXT(NUM_EXT), .NUM_DMA(NUM_DMA), .NUM_SER(NUM_SER),
                  .LVL_W(LVL_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lvl(src_lvl));

  vic_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
    .req(src_req), .lvl(src_lvl), .mask(cpu_mask),
    .win_valid(cand_valid), .win_idx(win_idx), .win_lvl(win_lvl));

  vic_code_gen #(.NUM_EXT(NUM_EXT), .NUM_DMA(NUM_DMA), .LVL_W(LVL_W),
                 .IDX_W(IDX_W)) u_code (
    .idx(win_idx), .lvl(win_lvl), .code_lvl(nxt_lvl_code), .code_src(nxt_src_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req      <= 1'b0;
      evt_code_lvl <= '0;
      evt_code_src <= '0;
    end else begin
      int_req <= cand_valid;
      if (accept) begin
        evt_code_lvl <= nxt_lvl_code;
        evt_code_src <= nxt_src_code;
      end
    end
  end

  assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!int_req && evt_code_src == '0 && evt_code_lvl == '0));

  assert_full_mask_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_mask == '1 && !nmi_in) |=> !int_req);

  assert_nmi_code_R8: assert property (@(posedge clk) disable iff (rst)
    (int_ack && nmi_in) |=> (evt_code_src == CODE_NMI && evt_code_lvl == CODE_NMI));

  assert_hold_codes_R10: assert property (@(posedge clk) disable iff (rst)
    !(int_ack && cand_valid) |=> ($stable(evt_code_src) && $stable(evt_code_lvl)));
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_in = 0, dbg_in = 0, int_ack = 0, reg_wr = 0;
  logic [5:0] ext_in = '0;
  logic [3:0] dma_in = '0, ser_in = '0, cpu_mask = '0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic int_req;
  logic [11:0] evt_code_lvl, evt_code_src;
  logic [15:0] reg_rdata;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [15:0] sh [3];
  logic exp_req;
  logic [11:0] exp_lvl, exp_src;
  logic [15:0] exp_rd;

  always #10 clk = ~clk;

  vic_top dut (.clk(clk), .rst(rst), .nmi_in(nmi_in), .dbg_in(dbg_in),
    .ext_in(ext_in), .dma_in(dma_in), .ser_in(ser_in), .cpu_mask(cpu_mask),
    .int_ack(int_ack), .int_req(int_req), .evt_code_lvl(evt_code_lvl),
    .evt_code_src(evt_code_src), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic int lvl_of(int i);
    if (i == 0) return 16;
    if (i == 1) return 15;
    if (i < 6) return int'(sh[0][(i-2)*4 +: 4]);
    if (i < 8) return int'(sh[1][(i-6)*4 +: 4]);
    if (i < 12) return int'(sh[2][15:12]);
    return int'(sh[2][7:4]);
  endfunction

  function automatic bit req_of(int i);
    logic [15:0] v;
    v = {ser_in, dma_in, ext_in, dbg_in, nmi_in};
    return v[i];
  endfunction

  function automatic int pick();
    int best, w;
    best = -1; w = -1;
    for (int i = 0; i < 16; i++)
      if (req_of(i) && lvl_of(i) > int'(cpu_mask) && lvl_of(i) > best) begin
        best = lvl_of(i); w = i;
      end
    return w;
  endfunction

  function automatic logic [11:0] src_code(int w);
    if (w == 0) return 12'h1C0;
    if (w == 1) return 12'h5E0;
    if (w < 8) return 12'(12'h600 + (w-2)*32);
    if (w < 12) return 12'(12'h800 + (w-8)*32);
    return 12'(12'h900 + (w-12)*32);
  endfunction

  function automatic logic [11:0] lvl_code(int w);
    if (w < 2) return src_code(w);
    return 12'(12'h200 + (15 - lvl_of(w))*32);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    int w;
    @(posedge clk);
    cycles++;
    if (rst) begin
      exp_req = 0; exp_lvl = '0; exp_src = '0; exp_rd = '0;
      for (int k = 0; k < 3; k++) sh[k] = '0;
    end else begin
      w = pick();
      exp_req = (w >= 0);
      if (int_ack && w >= 0) begin
        exp_lvl = lvl_code(w); exp_src = src_code(w);
      end
      exp_rd = (reg_addr == 2'd3) ? 16'h0 : sh[reg_addr];
      if (reg_wr) begin
        case (reg_addr)
          2'd0: sh[0] = reg_wdata;
          2'd1: sh[1] = reg_wdata & 16'h00FF;
          2'd2: sh[2] = reg_wdata & 16'hF0F0;
          default: ;
        endcase
      end
    end
    @(negedge clk);
    chk(int_req === exp_req, "R5 int_req", int'(int_req), int'(exp_req));
    chk(evt_code_src === exp_src, "R8 src code", int'(evt_code_src), int'(exp_src));
    chk(evt_code_lvl === exp_lvl, "R9 lvl code", int'(evt_code_lvl), int'(exp_lvl));
    chk(reg_rdata === exp_rd, "R2 rdata", int'(reg_rdata), int'(exp_rd));
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [15:0] e, string tag);
    reg_addr = a; step();
    chk(reg_rdata === e, tag, int'(reg_rdata), int'(e));
  endtask

  task automatic clr();
    nmi_in = 0; dbg_in = 0; ext_in = '0; dma_in = '0; ser_in = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 3; k++) sh[k] = '0;
    step(); step(); step();
    rst = 0;
    step();
    chk(!int_req && evt_code_src == 0 && evt_code_lvl == 0, "R1 outputs after reset",
        int'(evt_code_src), 0);
    rd_chk(2'd0, 16'h0, "R1 reg0"); rd_chk(2'd1, 16'h0, "R1 reg1"); rd_chk(2'd2, 16'h0, "R1 reg2");
    // R2 write and read-back with unimplemented bits
    wr(2'd0, 16'h4321); wr(2'd1, 16'hFF60); wr(2'd2, 16'hA5B7);
    rd_chk(2'd0, 16'h4321, "R2 reg0"); rd_chk(2'd1, 16'h0060, "R2 reg1");
    rd_chk(2'd2, 16'hA0B0, "R2 reg2"); rd_chk(2'd3, 16'h0, "R2 reg3");
    // R3 external line 4 has level 0
    int_ack = 1; ext_in = 6'b010000; step(); step();
    chk(!int_req, "R3 level0 no request", int'(int_req), 0);
    chk(evt_code_src == 12'h000, "R3 level0 not captured", int'(evt_code_src), 0);
    // R6 higher level wins: line3 (4) over line0 (1)
    ext_in = 6'b001001; step();
    chk(evt_code_src == 12'h660, "R6 highest level", int'(evt_code_src), 12'h660);
    chk(evt_code_lvl == 12'h360, "R9 level 4 code", int'(evt_code_lvl), 12'h360);
    // R7 ties
    wr(2'd0, 16'h5555);
    ext_in = 6'b000110; step();
    chk(evt_code_src == 12'h620, "R7 ext tie", int'(evt_code_src), 12'h620);
    clr(); dma_in = 4'b1110; step();
    chk(evt_code_src == 12'h820, "R7 dma tie", int'(evt_code_src), 12'h820);
    wr(2'd2, 16'hA0A0);
    ser_in = 4'b1100; step();
    chk(evt_code_src == 12'h820, "R7 dma before serial", int'(evt_code_src), 12'h820);
    dma_in = 4'b0000; step();
    chk(evt_code_src == 12'h940, "R7 serial tie", int'(evt_code_src), 12'h940);
    nmi_in = 1; dbg_in = 1; step();
    chk(evt_code_src == 12'h1C0, "R7 nmi first", int'(evt_code_src), 12'h1C0);
    clr(); dbg_in = 1; step();
    chk(evt_code_lvl == 12'h5E0, "R9 debug code", int'(evt_code_lvl), 12'h5E0);
    // R4 mask strictness
    clr(); int_ack = 0; dma_in = 4'b0001; cpu_mask = 4'd10; step();
    chk(!int_req, "R4 equal level masked", int'(int_req), 0);
    cpu_mask = 4'd9; step();
    chk(int_req, "R4 above mask", int'(int_req), 1);
    clr(); dbg_in = 1; cpu_mask = 4'd15; step();
    chk(!int_req, "R4 debug masked", int'(int_req), 0);
    nmi_in = 1; int_ack = 1; step();
    chk(int_req && evt_code_src == 12'h1C0, "R4 nmi unmaskable", int'(evt_code_src), 12'h1C0);
    // R10 hold without ack
    clr(); int_ack = 0; cpu_mask = 0; ser_in = 4'b0001; step(); step();
    chk(int_req && evt_code_src == 12'h1C0, "R10 hold without ack", int'(evt_code_src), 12'h1C0);
    int_ack = 1; step();
    chk(evt_code_src == 12'h900, "R10 capture on ack", int'(evt_code_src), 12'h900);
    // random phase compared with the model every cycle
    for (int n = 0; n < 600; n++) begin
      nmi_in = ($urandom_range(0, 15) == 0);
      dbg_in = ($urandom_range(0, 7) == 0);
      ext_in = 6'($urandom); dma_in = 4'($urandom); ser_in = 4'($urandom);
      cpu_mask = 4'($urandom); int_ack = 1'($urandom);
      reg_addr = 2'($urandom); reg_wdata = 16'($urandom);
      reg_wr = ($urandom_range(0, 5) == 0);
      step();
    end
    reg_wr = 0;
    finish_run();
  end
endmodule